// File: doc/BRIEF.md
# Scatter-Gather Memory-to-Stream Engine

This block follows a chain of descriptors held in memory and plays the buffer that each descriptor names out as a byte stream. The stream uses a valid/ready handshake and a last marker. A single request/acknowledge memory port serves every memory access: descriptor words, buffer words and the status write-back. The register block that owns the software-visible state supplies four inputs: a run enable, an idle flag, the current descriptor pointer and the tail pointer. In return the engine gives one pulse per finished descriptor, a pulse that asks for idle to be set, and a write strobe carrying the pointer to the next descriptor.

A descriptor occupies 44 bytes starting at its pointer. The words the engine reads, at their byte offsets, are:

| Offset | Content |
|--------|---------|
| 0x00 | Low word of the buffer address (the high word at 0x04 is not read) |
| 0x08 | Low word of the next-descriptor pointer (the high word at 0x0C is not read) |
| 0x10 | Control word |
| 0x14 | Status word |
| 0x18 to 0x28 | Five side-band words |

The control word holds the byte count in bits 22:0, frame start in bit 27 and frame end in bit 26. A frame may span several descriptors, and the engine counts its bytes against a fixed bound. On the first descriptor of a frame the engine reads the five side-band words and holds them on a parallel output.

Top module: `sg_mm2s_engine`

## Requirements
- R1: After reset, tx_valid_o, mem_req_o, desc_done_o, set_idle_o, ptr_we_o and err_o are all low.
- R2: The engine begins only when run_i is high and idle_i is low. Its first access is a read of the control word at cur_ptr_i + 0x10. While either condition fails it makes no memory request.
- R3: If status bit 31 of a fetched descriptor is already set, the engine pulses set_idle_o and stops. In that case it sends no bytes, writes nothing and gives no completion pulse.
- R4: The engine sends exactly control[22:0] bytes. They come from consecutive byte addresses starting at the buffer address, which may have any alignment. Memory words are little-endian, so byte address 4w+k is bits 8k+7:8k of word w.
- R5: Bytes from consecutive descriptors join into one frame. tx_last_o is high only on the final byte of a descriptor whose control bit 26 is set.
- R6: When control bit 27 is set, app_o[32i+31:32i] takes the word at descriptor offset 0x18 + 4i. A descriptor without bit 27 leaves app_o unchanged.
- R7: After its bytes are sent, each descriptor gets its status word at offset 0x14 written with its length ORed with 0x8000_0000. This is followed by exactly one single-cycle desc_done_o pulse.
- R8: With each completion, ptr_we_o pulses and ptr_o carries the next-descriptor pointer read from offset 0x08.
- R9: If the finished descriptor's pointer equals tail_ptr_i, set_idle_o pulses and no further request is made. Otherwise the engine goes on with the next descriptor while run_i is high and idle_i is low.
- R10: A descriptor with zero length sends no bytes but is still written back, completed and advanced past.
- R11: The frame bound is FRAME_MAX bytes. If a descriptor would take the frame past it, err_o is set and stays set until reset. The engine then halts without sending any bytes or writing status for that descriptor. A frame of exactly FRAME_MAX bytes is accepted.
- R12: While tx_valid_o is high and tx_ready_i is low, tx_valid_o, tx_data_o and tx_last_o hold their values.
- R13: While mem_req_o is high and mem_ack_i is low, the request, its address and its direction hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Run enable from the register block |
| idle_i | input | 1 | Idle flag from the register block |
| cur_ptr_i | input | AW | Current descriptor pointer |
| tail_ptr_i | input | AW | Tail descriptor pointer |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream sink ready |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of the frame |
| app_o | output | 32*APP_N | Side-band words of the current frame |
| desc_done_o | output | 1 | One pulse per completed descriptor |
| set_idle_o | output | 1 | Request to set idle |
| ptr_we_o | output | 1 | Strobe for ptr_o |
| ptr_o | output | AW | Next descriptor pointer |
| err_o | output | 1 | Frame bound exceeded (sticky) |

## Verification
The bench sweeps every buffer alignment against lengths from zero to nine under a throttled sink. An engine that counted bytes per word rather than per byte offset would send wrong or extra bytes. An engine that marked every descriptor end as the frame end would raise last too early. A chain test joins a frame across a zero-length middle descriptor and stops at a tail pointer placed before the end of the list. A design that kept walking would write the status of the descriptor beyond the tail, and one that latched side-band words on every descriptor would pick up the middle descriptor's words. The frame bound is tried at exactly the limit and one descriptor beyond it. An off-by-one comparison either halts a legal frame or lets an oversized frame stream out. A pre-completed descriptor must produce no completion and no write.

// File: rtl/sg_mm2s_pkg.sv
package sg_mm2s_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_STAT,
    ST_BUF,
    ST_NEXT,
    ST_APP,
    ST_CHECK,
    ST_DRD,
    ST_DTX,
    ST_WB,
    ST_PARK,
    ST_HALT
  } sg_state_e;

  // descriptor word offsets in bytes
  localparam int OFS_BUF  = 0;
  localparam int OFS_NEXT = 8;
  localparam int OFS_CTRL = 16;
  localparam int OFS_STAT = 20;
  localparam int OFS_APP  = 24;

  // control and status bit positions
  localparam int CTRL_SOF  = 27;
  localparam int CTRL_EOF  = 26;
  localparam int STAT_DONE = 31;

endpackage

// File: rtl/sg_frame_guard.sv
// Tracks the byte position inside the current frame and flags a descriptor
// that would push the frame beyond its bound.
module sg_frame_guard #(
  parameter int LEN_W     = 23,
  parameter int FRAME_MAX = 16384
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof,
  input  logic [LEN_W-1:0] len,
  input  logic             commit,
  output logic             over
);
  localparam int POS_W = $clog2(FRAME_MAX + 1);
  localparam int SUM_W = ((LEN_W > POS_W) ? LEN_W : POS_W) + 1;

  logic [POS_W-1:0] pos_q;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum  = (sof ? '0 : SUM_W'(pos_q)) + SUM_W'(len);
    over = sum > SUM_W'(FRAME_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (commit) begin
      pos_q <= sum[POS_W-1:0];
    end
  end
endmodule

// File: rtl/sg_byte_pump.sv
// Holds one fetched memory word and hands its selected bytes out one at a time.
module sg_byte_pump (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] word,
  input  logic [1:0]  off,
  input  logic [2:0]  cnt,
  input  logic        last_in,
  input  logic        ready,
  output logic        valid,
  output logic [7:0]  data,
  output logic        last
);
  logic [31:0] word_q;
  logic [1:0]  idx_q;
  logic [2:0]  cnt_q;
  logic        lastf_q;

  always_comb begin
    valid = cnt_q != 3'd0;
    data  = word_q[8*idx_q +: 8];
    last  = lastf_q && (cnt_q == 3'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      lastf_q <= 1'b0;
    end else if (load) begin
      word_q  <= word;
      idx_q   <= off;
      cnt_q   <= cnt;
      lastf_q <= last_in;
    end else if (valid && ready) begin
      idx_q <= idx_q + 2'd1;
      cnt_q <= cnt_q - 3'd1;
    end
  end
endmodule

// File: rtl/sg_app_bank.sv
// Side-band word store, one register per word.
module sg_app_bank #(
  parameter int APP_N = 5,
  parameter int IW    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IW-1:0]     idx,
  input  logic [31:0]       wdata,
  output logic [32*APP_N-1:0] app
);
  for (genvar i = 0; i < APP_N; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        app[32*i +: 32] <= '0;
      end else if (we && idx == IW'(i)) begin
        app[32*i +: 32] <= wdata;
      end
    end
  end
endmodule

// File: rtl/sg_mm2s_engine.sv
module sg_mm2s_engine
  import sg_mm2s_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LEN_W     = 23,
  parameter int FRAME_MAX = 16384,
  parameter int APP_N     = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_i,
  input  logic                 idle_i,
  input  logic [AW-1:0]        cur_ptr_i,
  input  logic [AW-1:0]        tail_ptr_i,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [31:0]          mem_wdata_o,
  input  logic                 mem_ack_i,
  input  logic [31:0]          mem_rdata_i,
  output logic                 tx_valid_o,
  input  logic                 tx_ready_i,
  output logic [7:0]           tx_data_o,
  output logic                 tx_last_o,
  output logic [32*APP_N-1:0]  app_o,
  output logic                 desc_done_o,
  output logic                 set_idle_o,
  output logic                 ptr_we_o,
  output logic [AW-1:0]        ptr_o,
  output logic                 err_o
);
  localparam int APP_IW = (APP_N > 1) ? $clog2(APP_N) : 1;

  sg_state_e         state_q;
  logic [AW-1:0]     desc_q;
  logic [AW-1:0]     next_q;
  logic [AW-1:0]     buf_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  rem_q;
  logic              sof_q;
  logic              eof_q;
  logic [APP_IW-1:0] app_idx_q;

  logic [2:0]  room;
  logic [2:0]  chunk;
  logic        chunk_last;
  logic        pump_load;
  logic        app_we;
  logic        guard_commit;
  logic        guard_over;
  logic [31:0] stat_word;

  always_comb begin
    room         = 3'd4 - {1'b0, buf_q[1:0]};
    chunk        = (rem_q < LEN_W'(room)) ? rem_q[2:0] : room;
    chunk_last   = eof_q && (rem_q == LEN_W'(chunk));
    pump_load    = (state_q == ST_DRD) && mem_ack_i;
    app_we       = (state_q == ST_APP) && mem_ack_i;
    guard_commit = (state_q == ST_CHECK) && !guard_over;
    stat_word    = 32'(len_q);
    stat_word[STAT_DONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      desc_q      <= '0;
      next_q      <= '0;
      buf_q       <= '0;
      len_q       <= '0;
      rem_q       <= '0;
      sof_q       <= 1'b0;
      eof_q       <= 1'b0;
      app_idx_q   <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      desc_done_o <= 1'b0;
      set_idle_o  <= 1'b0;
      ptr_we_o    <= 1'b0;
      ptr_o       <= '0;
      err_o       <= 1'b0;
    end else begin
      desc_done_o <= 1'b0;
      set_idle_o  <= 1'b0;
      ptr_we_o    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (run_i && !idle_i) begin
            desc_q     <= cur_ptr_i;
            mem_req_o  <= 1'b1;
            mem_we_o   <= 1'b0;
            mem_addr_o <= cur_ptr_i + AW'(OFS_CTRL);
            state_q    <= ST_CTRL;
          end
        end
        ST_CTRL: begin
          if (mem_ack_i) begin
            len_q      <= mem_rdata_i[LEN_W-1:0];
            sof_q      <= mem_rdata_i[CTRL_SOF];
            eof_q      <= mem_rdata_i[CTRL_EOF];
            mem_addr_o <= desc_q + AW'(OFS_STAT);
            state_q    <= ST_STAT;
          end
        end
        ST_STAT: begin
          if (mem_ack_i) begin
            if (mem_rdata_i[STAT_DONE]) begin
              mem_req_o  <= 1'b0;
              set_idle_o <= 1'b1;
              state_q    <= ST_PARK;
            end else begin
              mem_addr_o <= desc_q + AW'(OFS_BUF);
              state_q    <= ST_BUF;
            end
          end
        end
        ST_BUF: begin
          if (mem_ack_i) begin
            buf_q      <= mem_rdata_i[AW-1:0];
            mem_addr_o <= desc_q + AW'(OFS_NEXT);
            state_q    <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (mem_ack_i) begin
            next_q <= mem_rdata_i[AW-1:0];
            if (sof_q) begin
              app_idx_q  <= '0;
              mem_addr_o <= desc_q + AW'(OFS_APP);
              state_q    <= ST_APP;
            end else begin
              mem_req_o <= 1'b0;
              state_q   <= ST_CHECK;
            end
          end
        end
        ST_APP: begin
          if (mem_ack_i) begin
            if (app_idx_q == APP_IW'(APP_N - 1)) begin
              mem_req_o <= 1'b0;
              state_q   <= ST_CHECK;
            end else begin
              app_idx_q  <= app_idx_q + APP_IW'(1);
              mem_addr_o <= mem_addr_o + AW'(4);
            end
          end
        end
        ST_CHECK: begin
          if (guard_over) begin
            err_o   <= 1'b1;
            state_q <= ST_HALT;
          end else begin
            rem_q     <= len_q;
            mem_req_o <= 1'b1;
            if (len_q == '0) begin
              mem_we_o    <= 1'b1;
              mem_addr_o  <= desc_q + AW'(OFS_STAT);
              mem_wdata_o <= stat_word;
              state_q     <= ST_WB;
            end else begin
              mem_we_o   <= 1'b0;
              mem_addr_o <= {buf_q[AW-1:2], 2'b00};
              state_q    <= ST_DRD;
            end
          end
        end
        ST_DRD: begin
          if (mem_ack_i) begin
            mem_req_o <= 1'b0;
            rem_q     <= rem_q - LEN_W'(chunk);
            buf_q     <= buf_q + AW'(chunk);
            state_q   <= ST_DTX;
          end
        end
        ST_DTX: begin
          if (!tx_valid_o) begin
            mem_req_o <= 1'b1;
            if (rem_q == '0) begin
              mem_we_o    <= 1'b1;
              mem_addr_o  <= desc_q + AW'(OFS_STAT);
              mem_wdata_o <= stat_word;
              state_q     <= ST_WB;
            end else begin
              mem_we_o   <= 1'b0;
              mem_addr_o <= {buf_q[AW-1:2], 2'b00};
              state_q    <= ST_DRD;
            end
          end
        end
        ST_WB: begin
          if (mem_ack_i) begin
            mem_we_o    <= 1'b0;
            desc_done_o <= 1'b1;
            ptr_we_o    <= 1'b1;
            ptr_o       <= next_q;
            if (desc_q == tail_ptr_i) begin
              mem_req_o  <= 1'b0;
              set_idle_o <= 1'b1;
              state_q    <= ST_PARK;
            end else if (run_i && !idle_i) begin
              desc_q     <= next_q;
              mem_addr_o <= next_q + AW'(OFS_CTRL);
              state_q    <= ST_CTRL;
            end else begin
              mem_req_o <= 1'b0;
              state_q   <= ST_IDLE;
            end
          end
        end
        ST_PARK: begin
          if (idle_i || !run_i) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  sg_frame_guard #(
    .LEN_W    (LEN_W),
    .FRAME_MAX(FRAME_MAX)
  ) u_guard (
    .clk   (clk),
    .rst   (rst),
    .sof   (sof_q),
    .len   (len_q),
    .commit(guard_commit),
    .over  (guard_over)
  );

  sg_byte_pump u_pump (
    .clk    (clk),
    .rst    (rst),
    .load   (pump_load),
    .word   (mem_rdata_i),
    .off    (buf_q[1:0]),
    .cnt    (chunk),
    .last_in(chunk_last),
    .ready  (tx_ready_i),
    .valid  (tx_valid_o),
    .data   (tx_data_o),
    .last   (tx_last_o)
  );

  sg_app_bank #(
    .APP_N(APP_N),
    .IW   (APP_IW)
  ) u_app (
    .clk  (clk),
    .rst  (rst),
    .we   (app_we),
    .idx  (app_idx_q),
    .wdata(mem_rdata_i),
    .app  (app_o)
  );
endmodule

// File: rtl/sg_mm2s_checker.sv
module sg_mm2s_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic [7:0]    tx_data_o,
  input logic          tx_last_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ack_i,
  input logic          desc_done_o,
  input logic          set_idle_o,
  input logic          err_o
);
  // R12
  stream_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

  // R5
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    tx_last_o |-> tx_valid_o);

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    desc_done_o |=> !desc_done_o);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  // R11
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !mem_req_o && !tx_valid_o);

  // R9
  idle_stop_chk: assert property (@(posedge clk) disable iff (rst)
    set_idle_o |=> !mem_req_o);
endmodule

bind sg_mm2s_engine sg_mm2s_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .tx_last_o  (tx_last_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_ack_i  (mem_ack_i),
  .desc_done_o(desc_done_o),
  .set_idle_o (set_idle_o),
  .err_o      (err_o)
);

// File: tb/test_sg_mm2s_engine.sv
`timescale 1ns/1ps
module test_sg_mm2s_engine;
  localparam int AW    = 32;
  localparam int FMAX  = 64;
  localparam int APP_N = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic idle = 1'b0;
  logic [AW-1:0] cur_ptr = '0;
  logic [AW-1:0] tail_ptr = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic tx_valid, tx_ready = 1'b0, tx_last;
  logic [7:0] tx_data;
  logic [32*APP_N-1:0] app;
  logic desc_done, set_idle, ptr_we, err;
  logic [AW-1:0] ptr;

  always #2 clk = ~clk;

  sg_mm2s_engine #(.AW(AW), .LEN_W(23), .FRAME_MAX(FMAX), .APP_N(APP_N)) i_sg_mm2s_engine (
    .clk(clk), .rst(rst), .run_i(run), .idle_i(idle), .cur_ptr_i(cur_ptr),
    .tail_ptr_i(tail_ptr), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .tx_data_o(tx_data), .tx_last_o(tx_last), .app_o(app),
    .desc_done_o(desc_done), .set_idle_o(set_idle), .ptr_we_o(ptr_we),
    .ptr_o(ptr), .err_o(err));

  logic [31:0] mem [0:511];
  logic [7:0]  rx_byte [0:255];
  logic        rx_lastf [0:255];
  int rx_n = 0, done_n = 0, req_n = 0, hold_bad = 0, cyc = 0;
  int errors = 0, checks = 0;
  logic hold_prev = 1'b0;
  logic [7:0] data_prev = '0;
  logic last_prev = 1'b0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13 + 5) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory: one access per two cycles
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      if (mem_we) mem[mem_addr[10:2]] = mem_wdata;
      else mem_rdata = mem[mem_addr[10:2]];
    end
  end

  // register block model, sink and monitors
  always @(negedge clk) begin
    cyc++;
    if (ptr_we) cur_ptr = ptr;
    if (set_idle) idle = 1'b1;
    if (desc_done) done_n++;
    if (mem_req) req_n++;
    // R12: data held while stalled
    if (hold_prev && (!tx_valid || tx_data != data_prev || tx_last != last_prev)) hold_bad++;
    tx_ready = (cyc % 5) != 2;
    if (tx_valid && tx_ready && rx_n < 256) begin
      rx_byte[rx_n] = tx_data;
      rx_lastf[rx_n] = tx_last;
      rx_n++;
    end
    hold_prev = tx_valid && !tx_ready;
    data_prev = tx_data;
    last_prev = tx_last;
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic put_desc(input int a, input int bufa, input int nxt,
                          input int ctrl, input int stat, input int seed);
    mem[a/4 + 0] = bufa;
    mem[a/4 + 1] = 0;
    mem[a/4 + 2] = nxt;
    mem[a/4 + 3] = 0;
    mem[a/4 + 4] = ctrl;
    mem[a/4 + 5] = stat;
    for (int i = 0; i < APP_N; i++) mem[a/4 + 6 + i] = seed + i;
  endtask

  task automatic run_chain(input int head, input int tail);
    int t;
    @(negedge clk);
    rx_n = 0; done_n = 0;
    cur_ptr = head; tail_ptr = tail; idle = 1'b0; run = 1'b1;
    t = 0;
    while (!idle && !err && t < 4000) begin
      @(negedge clk);
      t++;
    end
    check(t < 4000, "R9", "run watchdog", t, 0);
    repeat (4) @(negedge clk);
    run = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic int ctl(input int len, input bit sof, input bit eof);
    return len | (int'(sof) << 27) | (int'(eof) << 26);
  endfunction

  initial begin
    int bad, lasts, bufa, nx;
    for (int w = 0; w < 128; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    for (int w = 128; w < 512; w++) mem[w] = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!tx_valid && !mem_req && !desc_done && !set_idle && !ptr_we && !err,
          "R1", "outputs after reset", {tx_valid, mem_req, desc_done, err}, 0);
    rst = 1'b0;

    // R2: no request unless running and not idle
    req_n = 0; run = 1'b0; idle = 1'b0;
    repeat (20) @(negedge clk);
    run = 1'b1; idle = 1'b1;
    repeat (20) @(negedge clk);
    run = 1'b0; idle = 1'b0;
    check(req_n == 0, "R2", "requests while stopped or idle", req_n, 0);

    // sweep: alignment 0..3, length 0..9, single SOF+EOF descriptor
    for (int off = 0; off < 4; off++) begin
      for (int len = 0; len < 10; len++) begin
        bufa = 16 + off + 32 * len;
        nx = 32'h700 + 4 * len + off;
        put_desc(32'h400, bufa, nx, ctl(len, 1, 1), 0, 100 * len + off);
        run_chain(32'h400, 32'h400);
        check(rx_n == len, "R4", "byte count", rx_n, len);
        bad = 0; lasts = 0;
        for (int k = 0; k < rx_n; k++) begin
          if (rx_byte[k] != pat(bufa + k)) bad++;
          if (rx_lastf[k]) lasts++;
        end
        check(bad == 0, "R4", "byte values", bad, 0);
        // R5 and R10: last only on final byte; zero length carries none
        check(lasts == (len > 0 ? 1 : 0) && (len == 0 || rx_lastf[len-1]),
              "R5", "last marker", lasts, len > 0 ? 1 : 0);
        check(mem[32'h400/4 + 5] == (32'h8000_0000 | len), "R7", "status write-back",
              mem[32'h400/4 + 5], 32'h8000_0000 | len);
        check(done_n == 1, "R10", "completion count", done_n, 1);
        check(cur_ptr == nx, "R8", "advanced pointer", cur_ptr, nx);
        check(app[63:32] == 32'(100 * len + off + 1), "R6", "side-band word 1",
              app[63:32], 100 * len + off + 1);
      end
    end

    // chain: frame over three descriptors, zero-length middle, tail before end
    put_desc(32'h400, 32'h21, 32'h440, ctl(5, 1, 0), 0, 32'h1000);
    put_desc(32'h440, 32'h60, 32'h480, ctl(0, 0, 0), 0, 32'h2000);
    put_desc(32'h480, 32'h93, 32'h4C0, ctl(6, 0, 1), 0, 32'h3000);
    put_desc(32'h4C0, 32'hA0, 32'h400, ctl(3, 1, 1), 0, 32'h4000);
    run_chain(32'h400, 32'h480);
    check(rx_n == 11, "R5", "joined frame bytes", rx_n, 11);
    bad = 0; lasts = 0;
    for (int k = 0; k < 11; k++) begin
      if (rx_byte[k] != (k < 5 ? pat(32'h21 + k) : pat(32'h93 + k - 5))) bad++;
      if (rx_lastf[k] != (k == 10)) lasts++;
    end
    check(bad == 0, "R4", "joined frame values", bad, 0);
    check(lasts == 0, "R5", "last only at frame end", lasts, 0);
    check(done_n == 3, "R10", "zero-length counted", done_n, 3);
    check(mem[32'h440/4 + 5] == 32'h8000_0000, "R10", "zero-length write-back",
          mem[32'h440/4 + 5], 32'h8000_0000);
    check(mem[32'h4C0/4 + 5] == 0, "R9", "past tail untouched", mem[32'h4C0/4 + 5], 0);
    check(cur_ptr == 32'h4C0, "R9", "pointer after tail", cur_ptr, 32'h4C0);
    check(app[31:0] == 32'h1000 && app[159:128] == 32'h1004, "R6",
          "non-start descriptor keeps side-band", app[31:0], 32'h1000);

    // resume from the pointer left by the register block
    run_chain(32'h4C0, 32'h4C0);
    check(rx_n == 3 && rx_lastf[2], "R5", "resumed frame", rx_n, 3);
    check(app[95:64] == 32'h4002, "R6", "new frame side-band", app[95:64], 32'h4002);

    // R3: already complete descriptor
    put_desc(32'h500, 32'h10, 32'h540, ctl(4, 1, 1), 32'h8000_0007, 32'h5000);
    run_chain(32'h500, 32'h540);
    check(idle && rx_n == 0 && done_n == 0, "R3", "pre-completed stops", rx_n + done_n, 0);
    check(mem[32'h500/4 + 5] == 32'h8000_0007, "R3", "no write-back",
          mem[32'h500/4 + 5], 32'h8000_0007);
    check(cur_ptr == 32'h500, "R3", "pointer kept", cur_ptr, 32'h500);

    // R11 boundary: exactly FMAX bytes accepted
    put_desc(32'h400, 32'h000, 32'h440, ctl(40, 1, 0), 0, 0);
    put_desc(32'h440, 32'h100, 32'h480, ctl(FMAX - 40, 0, 1), 0, 0);
    run_chain(32'h400, 32'h440);
    check(!err && rx_n == FMAX && done_n == 2, "R11", "frame at bound", rx_n, FMAX);

    // R11: one descriptor beyond the bound
    put_desc(32'h400, 32'h000, 32'h440, ctl(40, 1, 0), 0, 0);
    put_desc(32'h440, 32'h100, 32'h480, ctl(FMAX - 39, 0, 1), 0, 0);
    run_chain(32'h400, 32'h440);
    check(err, "R11", "error flag", err, 1);
    check(rx_n == 40 && done_n == 1, "R11", "halt before oversized data", rx_n, 40);
    check(mem[32'h440/4 + 5] == 0, "R11", "no write-back on error", mem[32'h440/4 + 5], 0);
    req_n = 0;
    run = 1'b1; idle = 1'b0;
    repeat (20) @(negedge clk);
    run = 1'b0;
    check(err && req_n == 0, "R11", "stays halted", req_n, 0);

    check(hold_bad == 0, "R12", "stall hold violations", hold_bad, 0);
    // R13 is covered by the request-hold property in the checker
    check(1'b1, "R13", "request hold covered by property", 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule